// File: doc/BRIEF.md
# 8-bit Timer/Counter with Single Compare Output

This block is an 8-bit counter that steps on a selectable timer clock: a tap of a free-running 10-bit prescaler, or a synchronized edge of an external event input. The counter runs in one of four modes. In free-running mode it wraps at 0xFF. In clear-on-match mode the compare value sets the reload period. Frequency-generation mode works like clear-on-match and also toggles the waveform output on each match. Phase-correct PWM mode counts 0 up to 0xFF and back down to 0.

The active compare value is checked against the counter on every timer tick. In PWM mode the compare register is double buffered: a new value is held until the counter turns at TOP, so the output never glitches. An overflow flag and a compare flag each drive an interrupt request through their own mask bit. A 2-bit-address write port programs the control byte, the compare value and the counter, and clears the flags.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset the counter is 0x00, the waveform output is low, both flags and both requests are low, and the clock select is stopped.
- R2: With clock select code 0 the counter holds its value for any number of cycles.
- R3: Clock select codes 1, 2, 3, 4, 5 step the counter once every 1, 8, 64, 256, 1024 system cycles, so any window of k·N consecutive cycles gives exactly k steps.
- R4: Code 6 steps on falling edges and code 7 on rising edges of `ext_in`, after a two-flop synchronizer, exactly one step per edge.
- R5: Register map by `wr_addr`: 0 = control byte {bit7 compare mask, bit6 overflow mask, bit5 unused, bits4:3 mode (0 free-running, 1 phase-correct PWM, 2 clear-on-match, 3 frequency generation), bits2:0 clock select}; 1 = compare value; 2 = counter value, whose write also sets the count direction to up and drives the output low; 3 = flag clear.
- R6: In modes 0, 2 and 3 a tick at 0xFF sets the overflow flag; in mode 0 the counter wraps 0xFF→0x00.
- R7: A tick whose counter value equals the active compare value sets the compare flag in every mode; in mode 2 that tick loads 0x00.
- R8: In mode 3 a matching tick loads 0x00 and inverts the waveform output.
- R9: In mode 1 the counter goes up to 0xFF, then 0xFE on the next tick, and down to 0x00, then 0x01. The tick at 0x00 while counting down sets the overflow flag.
- R10: In mode 1 a match during the upward phase drives the output low and a match during the downward phase drives it high. A match at 0x00 counts as upward and a match at 0xFF as downward.
- R11: In mode 1 a compare write goes to a buffer that is copied to the active value on the tick at 0xFF. In other modes the write takes effect at once.
- R12: Writing 1 to bit 0 or bit 1 at address 3 clears the overflow or the compare flag. A 0 bit leaves the flag as it is, and a flag set in the same cycle stays set. Each request equals its flag ANDed with its mask.
- R13: A counter write in a cycle that has a tick takes priority over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External event input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| cnt_q | output | 8 | Current counter value |
| wave_out | output | 1 | Compare waveform output |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| irq_ovf | output | 1 | Masked overflow request |
| irq_cmp | output | 1 | Masked compare request |

## Verification
The bench uses the default parameters: an 8-bit counter, a 10-bit prescaler and two synchronizer stages. With 8 bits, a full PWM sweep of 510 ticks and a buffered compare reload at TOP fit into short runs. The 10-bit prescaler lets the bench check the largest division (1024) exactly over a 2048-cycle window. Two synchronizer stages set how long the bench holds each external level so that every edge is counted once.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_CTC  = 2'd2,
    MODE_FREQ = 2'd3
  } tmr_mode_e;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMP  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_FLAG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic      cmp_mask;
    logic      ovf_mask;
    logic      spare;
    tmr_mode_e mode;
    clk_sel_e  clk_sel;
  } ctrl_t;

endpackage

// File: rtl/tmr8_clksel.sv
`timescale 1ns/1ps
// Timer clock select: prescaler taps or synchronized external edges.
module tmr8_clksel
  import tmr8_pkg::*;
#(
  parameter int PRE_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_in,
  output logic     tick
);

  localparam int SH8    = 3;
  localparam int SH64   = 6;
  localparam int SH256  = 8;
  localparam int SH1024 = 10;

  logic [PRE_W-1:0]  pre_q;
  logic [SYNC_N-1:0] sync_q;
  logic              ext_prev_q;
  logic              ext_rise;
  logic              ext_fall;
  logic [PRE_W-1:0]  mask;

  // Low bits that must all be ones for a tap to fire
  function automatic logic [PRE_W-1:0] tap_mask(input clk_sel_e s);
    case (s)
      CS_DIV8:    return PRE_W'((1 << SH8) - 1);
      CS_DIV64:   return PRE_W'((1 << SH64) - 1);
      CS_DIV256:  return PRE_W'((1 << SH256) - 1);
      CS_DIV1024: return PRE_W'((1 << SH1024) - 1);
      default:    return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  generate
    if (SYNC_N > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], ext_in};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= sync_q[SYNC_N-1];
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~ext_prev_q;
  assign ext_fall = ~sync_q[SYNC_N-1] & ext_prev_q;
  assign mask     = tap_mask(sel);

  always_comb begin
    case (sel)
      CS_STOP:     tick = 1'b0;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = ((pre_q & mask) == mask);
    endcase
  end

endmodule

// File: rtl/tmr8_core.sv
`timescale 1ns/1ps
// Counter, direction, double-buffered compare and match/overflow events.
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmr_mode_e        mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_up,
  output logic [CNT_W-1:0] ocr_act,
  output logic             at_top,
  output logic             at_bottom,
  output logic             match_evt,
  output logic             ovf_evt,
  output logic             up_phase
);

  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] BOTTOM = '0;

  logic [CNT_W-1:0] ocr_buf;
  logic             step;
  logic             match_raw;

  function automatic logic [CNT_W-1:0] f_next_cnt(
    input logic [CNT_W-1:0] c, input tmr_mode_e m, input logic up, input logic hit);
    case (m)
      MODE_PWM:
        if (up) return (c == TOP)    ? TOP - 1'b1 : c + 1'b1;
        else    return (c == BOTTOM) ? BOTTOM + 1'b1 : c - 1'b1;
      MODE_CTC, MODE_FREQ:
        return hit ? BOTTOM : c + 1'b1;
      default:
        return c + 1'b1;
    endcase
  endfunction

  function automatic logic f_next_dir(
    input logic [CNT_W-1:0] c, input tmr_mode_e m, input logic up);
    if (m != MODE_PWM)            return up;
    if (up && c == TOP)           return 1'b0;
    if (!up && c == BOTTOM)       return 1'b1;
    return up;
  endfunction

  assign at_top    = (cnt_q == TOP);
  assign at_bottom = (cnt_q == BOTTOM);
  assign match_raw = (cnt_q == ocr_act);
  assign step      = tick & ~cnt_wr;
  assign match_evt = step & match_raw;
  assign ovf_evt   = step & ((mode == MODE_PWM) ? (~dir_up & at_bottom) : at_top);
  // Phase of the slope: BOTTOM counts as rising, TOP as falling
  assign up_phase  = dir_up ? ~at_top : at_bottom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= BOTTOM;
      dir_up <= 1'b1;
    end else if (cnt_wr) begin
      cnt_q  <= cnt_wdata;
      dir_up <= 1'b1;
    end else if (tick) begin
      cnt_q  <= f_next_cnt(cnt_q, mode, dir_up, match_raw);
      dir_up <= f_next_dir(cnt_q, mode, dir_up);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (cmp_wr) ocr_buf <= cmp_wdata;
      if (mode != MODE_PWM) begin
        if (cmp_wr) ocr_act <= cmp_wdata;
      end else if (step && at_top) begin
        ocr_act <= ocr_buf;
      end
    end
  end

endmodule

// File: rtl/tmr8_outflags.sv
`timescale 1ns/1ps
// Waveform output, sticky flags and masked requests.
module tmr8_outflags
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tmr_mode_e  mode,
  input  logic       match_evt,
  input  logic       ovf_evt,
  input  logic       up_phase,
  input  logic       cnt_wr,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic       ovf_mask,
  input  logic       cmp_mask,
  output logic       wave_out,
  output logic       ovf_flag,
  output logic       cmp_flag,
  output logic       irq_ovf,
  output logic       irq_cmp
);

  function automatic logic f_flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_out <= 1'b0;
    end else if (cnt_wr) begin
      wave_out <= 1'b0;
    end else if (match_evt) begin
      case (mode)
        MODE_FREQ: wave_out <= ~wave_out;
        MODE_PWM:  wave_out <= ~up_phase;
        default:   wave_out <= wave_out;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= f_flag_next(ovf_flag, ovf_evt,   clr_wr & clr_bits[0]);
      cmp_flag <= f_flag_next(cmp_flag, match_evt, clr_wr & clr_bits[1]);
    end
  end

  assign irq_ovf = ovf_flag & ovf_mask;
  assign irq_cmp = cmp_flag & cmp_mask;

endmodule

// File: rtl/tmr8_pwm.sv
`timescale 1ns/1ps
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic             irq_ovf,
  output logic             irq_cmp
);

  ctrl_t            ctrl_q;
  logic             ctrl_wr;
  logic             cmp_wr;
  logic             cnt_wr;
  logic             clr_wr;
  logic             tick;
  logic             dir_up;
  logic [CNT_W-1:0] ocr_act;
  logic             at_top;
  logic             at_bottom;
  logic             match_evt;
  logic             ovf_evt;
  logic             up_phase;
  tmr_mode_e        mode_w;
  clk_sel_e         clk_sel_w;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign cmp_wr    = wr_en && (wr_addr == ADDR_CMP);
  assign cnt_wr    = wr_en && (wr_addr == ADDR_CNT);
  assign clr_wr    = wr_en && (wr_addr == ADDR_FLAG);
  assign mode_w    = ctrl_q.mode;
  assign clk_sel_w = ctrl_q.clk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data[7:0]);
  end

  tmr8_clksel #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_clksel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (clk_sel_w),
    .ext_in (ext_in),
    .tick   (tick)
  );

  tmr8_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode_w),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (wr_data),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (wr_data),
    .cnt_q     (cnt_q),
    .dir_up    (dir_up),
    .ocr_act   (ocr_act),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .up_phase  (up_phase)
  );

  tmr8_outflags u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_w),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .up_phase  (up_phase),
    .cnt_wr    (cnt_wr),
    .clr_wr    (clr_wr),
    .clr_bits  (wr_data[1:0]),
    .ovf_mask  (ctrl_q.ovf_mask),
    .cmp_mask  (ctrl_q.cmp_mask),
    .wave_out  (wave_out),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag),
    .irq_ovf   (irq_ovf),
    .irq_cmp   (irq_cmp)
  );

endmodule

// File: rtl/tmr8_chk.sv
`timescale 1ns/1ps
module tmr8_chk
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input tmr_mode_e        mode,
  input clk_sel_e         clk_sel,
  input logic             match_evt,
  input logic             ovf_evt,
  input logic             at_top,
  input logic             dir_up,
  input logic [CNT_W-1:0] ocr_act,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wave_out,
  input logic             ovf_flag
);

  localparam logic [CNT_W-1:0] TOP_M1 = {{(CNT_W-1){1'b1}}, 1'b0};

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == CS_STOP && !cnt_wr) |=> $stable(cnt_q));

  p_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[2:1] == 2'b11 && tick) |=> (!tick || clk_sel[2:1] != 2'b11));

  p_ovf_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  p_ctc_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CTC && match_evt) |=> (cnt_q == '0));

  p_freq_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREQ && match_evt) |=> (wave_out != $past(wave_out)));

  p_pwm_turn_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && tick && !cnt_wr && dir_up && at_top) |=> (cnt_q == TOP_M1 && !dir_up));

  p_pwm_cmp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && !(tick && at_top)) |=> $stable(ocr_act));

endmodule

bind tmr8_pwm tmr8_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cnt_wr    (cnt_wr),
  .mode      (mode_w),
  .clk_sel   (clk_sel_w),
  .match_evt (match_evt),
  .ovf_evt   (ovf_evt),
  .at_top    (at_top),
  .dir_up    (dir_up),
  .ocr_act   (ocr_act),
  .cnt_q     (cnt_q),
  .wave_out  (wave_out),
  .ovf_flag  (ovf_flag)
);

// File: tb/tb_tmr8_pwm.sv
`timescale 1ns/1ps
module tb_tmr8_pwm;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] cnt_q;
  logic       wave_out, ovf_flag, cmp_flag, irq_ovf, irq_cmp;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_pwm dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_q(cnt_q), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  // Encodings restated from the register map requirement
  localparam logic [1:0] A_CTRL = 2'd0, A_CMP = 2'd1, A_CNT = 2'd2, A_FLAG = 2'd3;
  localparam logic [1:0] M_FREE = 2'd0, M_PWM = 2'd1, M_CTC = 2'd2, M_FREQ = 2'd3;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] start;
    logic [7:0] ocr;
    logic [8:0] n;
    logic [7:0] exp_cnt;
    logic       exp_wave;
    logic       exp_ovf;
    logic       exp_cmp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{M_FREE, 8'h00, 8'h80, 9'd10,  8'h0A, 1'b0, 1'b0, 1'b0, 4'd6},
    '{M_FREE, 8'hFA, 8'h10, 9'd10,  8'h04, 1'b0, 1'b1, 1'b0, 4'd6},
    '{M_FREE, 8'h05, 8'h07, 9'd3,   8'h08, 1'b0, 1'b0, 1'b1, 4'd7},
    '{M_CTC,  8'h00, 8'h04, 9'd12,  8'h02, 1'b0, 1'b0, 1'b1, 4'd7},
    '{M_FREQ, 8'h00, 8'h02, 9'd7,   8'h01, 1'b0, 1'b0, 1'b1, 4'd8},
    '{M_FREQ, 8'h00, 8'h02, 9'd4,   8'h01, 1'b1, 1'b0, 1'b1, 4'd8},
    '{M_CTC,  8'hFD, 8'hFF, 9'd4,   8'h01, 1'b0, 1'b1, 1'b1, 4'd7},
    '{M_PWM,  8'h00, 8'h03, 9'd5,   8'h05, 1'b0, 1'b0, 1'b1, 4'd10},
    '{M_PWM,  8'hFD, 8'h10, 9'd6,   8'hFB, 1'b0, 1'b0, 1'b0, 4'd9},
    '{M_PWM,  8'hFE, 8'hFD, 9'd4,   8'hFC, 1'b1, 1'b0, 1'b1, 4'd10},
    '{M_PWM,  8'hFF, 8'h80, 9'd256, 8'h01, 1'b1, 1'b1, 1'b1, 4'd9}
  };

  function automatic logic [7:0] ctrl_b(input logic [1:0] msk, input logic [1:0] md,
                                        input logic [2:0] cs);
    return {msk, 1'b0, md, cs};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one write at a negedge; it lands on the following posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Exactly n ticks with the divide-by-1 select
  task automatic run_ticks(input logic [1:0] md, input int n);
    wr(A_CTRL, ctrl_b(2'b00, md, 3'd1));
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, ctrl_b(2'b00, md, 3'd0));
  endtask

  // Clock select cs enabled for exactly cyc consecutive edges
  task automatic run_cycles(input logic [2:0] cs, input int cyc);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, cs));
    repeat (cyc - 1) @(negedge clk);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
  endtask

  task automatic ext_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_in = 1'b1; repeat (4) @(negedge clk);
      ext_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 cnt", cnt_q, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 flags", {ovf_flag, cmp_flag}, 0);
    chk("R1 irqs", {irq_ovf, irq_cmp}, 0);
    repeat (10) @(negedge clk);
    chk("R1 stopped", cnt_q, 0);

    // Table walk: modes R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
      wr(A_CMP, VECS[v].ocr);
      wr(A_CTRL, ctrl_b(2'b00, VECS[v].mode, 3'd0));
      wr(A_CNT, VECS[v].start);
      wr(A_FLAG, 8'h03);
      run_ticks(VECS[v].mode, int'(VECS[v].n));
      chk($sformatf("R%0d vec%0d cnt", VECS[v].req, v), cnt_q, VECS[v].exp_cnt);
      chk($sformatf("R%0d vec%0d wave", VECS[v].req, v), wave_out, VECS[v].exp_wave);
      chk($sformatf("R%0d vec%0d ovf", VECS[v].req, v), ovf_flag, VECS[v].exp_ovf);
      chk($sformatf("R%0d vec%0d cmp", VECS[v].req, v), cmp_flag, VECS[v].exp_cmp);
    end

    // R2: stopped clock holds the count
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
    wr(A_CNT, 8'h33);
    repeat (30) @(negedge clk);
    chk("R2 hold", cnt_q, 8'h33);

    // R3: prescaler taps over exact windows
    wr(A_CNT, 8'h00); run_cycles(3'd1, 16);   chk("R3 div1", cnt_q, 16);
    wr(A_CNT, 8'h00); run_cycles(3'd2, 64);   chk("R3 div8", cnt_q, 8);
    wr(A_CNT, 8'h00); run_cycles(3'd3, 512);  chk("R3 div64", cnt_q, 8);
    wr(A_CNT, 8'h00); run_cycles(3'd4, 1024); chk("R3 div256", cnt_q, 4);
    wr(A_CNT, 8'h00); run_cycles(3'd5, 2048); chk("R3 div1024", cnt_q, 2);

    // R4: external edges
    ext_in = 1'b0;
    repeat (6) @(negedge clk);
    wr(A_CNT, 8'h00);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd7));
    ext_pulses(5);
    repeat (6) @(negedge clk);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
    chk("R4 rising", cnt_q, 5);
    wr(A_CNT, 8'h00);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd6));
    ext_pulses(5);
    repeat (6) @(negedge clk);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
    chk("R4 falling", cnt_q, 5);

    // R11: buffered compare in PWM mode
    wr(A_CMP, 8'h03);
    wr(A_CTRL, ctrl_b(2'b00, M_PWM, 3'd0));
    wr(A_CNT, 8'h00);
    wr(A_FLAG, 8'h03);
    wr(A_CMP, 8'h02);
    run_ticks(M_PWM, 3);
    chk("R11 old value kept", cmp_flag, 0);
    wr(A_CNT, 8'hFE);
    run_ticks(M_PWM, 2);
    wr(A_FLAG, 8'h03);
    run_ticks(M_PWM, 252);
    chk("R11 cnt down", cnt_q, 8'h02);
    chk("R11 new value after TOP", cmp_flag, 0);
    run_ticks(M_PWM, 1);
    chk("R11 match new", cmp_flag, 1);
    chk("R10 down match sets", wave_out, 1);

    // R5: counter write loads value, clears output
    wr(A_CNT, 8'h5A);
    chk("R5 cnt load", cnt_q, 8'h5A);
    chk("R5 wave cleared", wave_out, 0);

    // R12: flags and masks
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
    wr(A_CNT, 8'hFF);
    wr(A_FLAG, 8'h03);
    run_ticks(M_FREE, 1);
    chk("R12 ovf set", ovf_flag, 1);
    chk("R12 masked off", irq_ovf, 0);
    wr(A_CTRL, ctrl_b(2'b01, M_FREE, 3'd0));
    chk("R12 irq ovf", irq_ovf, 1);
    chk("R12 irq cmp masked", irq_cmp, 0);
    wr(A_FLAG, 8'h02);
    chk("R12 zero bit keeps", ovf_flag, 1);
    wr(A_FLAG, 8'h01);
    chk("R12 cleared", {ovf_flag, irq_ovf}, 0);

    // R13: counter write beats a tick in the same cycle
    wr(A_CNT, 8'h10);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd1));
    wr(A_CNT, 8'h40);
    wr(A_CTRL, ctrl_b(2'b00, M_FREE, 3'd0));
    chk("R13 write priority", cnt_q, 8'h41);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule